// File: doc/BRIEF.md
# Serial-Rate Tick Selector with In-Band Rate Commands

This block sits between a host UART and an infrared coder. It produces the
16x bit-clock tick that paces both directions of the link, dividing the system
clock by a divisor picked in one of two ways. In pin mode a 3-bit select
input fixes the divisor directly. In software mode the host chooses the rate
itself. It first sends a rate byte, which is only staged. It then sends a separate commit byte, and
the staged rate becomes active once the echo of that commit byte has finished
its stop bit.

While software mode is selected and the mode input is low, the block is in
command mode. It echoes the host's serial line back to the host, delayed by a fixed
number of ticks, and it decodes the bytes it sees. No infrared coding takes place in this mode.
A ready flag stays low for a programmable number of clock cycles after reset
release and after the enable input rises. While the flag is low no tick is produced and no
command is accepted.

Top module: `irb_baud_sel`

## Requirements
- R1: In pin mode the tick period in system clocks is 48, 24, 12, 8 or 4 for select codes 000, 001, 010, 011 and 100. No two ticks are adjacent, and the gap between ticks never exceeds 48 cycles.
- R2: Select code 111 chooses software mode. After reset its rate is the 48-cycle tick.
- R3: ready is low while en is low. After en rises, or after reset release, ready rises after STARTUP_CYC (default 1000) cycles. No tick is produced while ready is low.
- R4: In command mode (select 111, mode_n low, ready high) echo_rx reproduces host_tx delayed by 8 ticks. Otherwise echo_rx is held high.
- R5: In command mode, rate bytes 0x87, 0x8B, 0x85, 0x83 and 0x81 (framed 8N1, LSB first, at the current rate) stage tick periods 48, 24, 12, 8 and 4. A following byte 0x11 makes the staged rate active.
- R6: After 0x11 the old rate stays in force until the echo of its stop bit has completed (16 ticks after the stop bit is sampled).
- R7: Any byte other than the five rate bytes and 0x11 is ignored and leaves the staged rate unchanged.
- R8: 0x11 received with no rate byte staged since reset keeps the current rate.
- R9: A byte whose stop bit samples low is discarded.
- R10: With mode_n high (data mode), bytes on host_tx neither change the rate nor appear on echo_rx.
- R11: Switching to a pin code overrides the software rate. Returning to code 111 restores the last committed software rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System (oscillator) clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Block enable; low forces the idle state |
| baud_sel | input | 3 | Rate select: 000..100 pin rates, 111 software mode |
| mode_n | input | 1 | Low selects command mode in software mode |
| host_tx | input | 1 | Serial line from the host UART |
| tick | output | 1 | One-cycle 16x bit-clock pulse |
| echo_rx | output | 1 | Echoed serial line to the host (idle high) |
| ready | output | 1 | High once the startup delay has elapsed |

## Verification
The bench attacks the commit path from every side. It sends a commit with nothing staged, a
reserved byte placed between a rate byte and the commit, a rate byte with a low stop bit,
and rate bytes sent in data mode. A design that staged on any received byte, took
a broken frame, or listened in data mode would land on a wrong tick period.
The bench also times the interval right after the commit byte. A design that
switched at the stop-bit sample rather than after the echoed stop bit would
show the new period there too early. The startup window is measured after both reset
and enable, and a design that kept ticking or accepted the line during it would be caught.

// File: rtl/irb_pkg.sv
package irb_pkg;
  localparam int DIV_W      = 6;
  localparam int SEL_W      = 3;
  localparam int BYTE_W     = 8;
  localparam int OVS        = 16;
  localparam logic [SEL_W-1:0]  SEL_SOFT   = 3'b111;
  localparam logic [BYTE_W-1:0] CMD_COMMIT = 8'h11;

  typedef enum logic [0:0] {RX_IDLE, RX_FRAME} rx_state_e;

  function automatic logic [DIV_W-1:0] sel_div(input logic [SEL_W-1:0] sel);
    case (sel)
      3'b001:  return 6'd24;
      3'b010:  return 6'd12;
      3'b011:  return 6'd8;
      3'b100:  return 6'd4;
      default: return 6'd48;
    endcase
  endfunction

  function automatic logic [SEL_W-1:0] cmd_code(input logic [BYTE_W-1:0] b);
    case (b)
      8'h87:   return 3'b000;
      8'h8B:   return 3'b001;
      8'h85:   return 3'b010;
      8'h83:   return 3'b011;
      8'h81:   return 3'b100;
      default: return SEL_SOFT;
    endcase
  endfunction
endpackage

// File: rtl/irb_startup.sv
module irb_startup #(
  parameter int STARTUP_CYC = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic ready
);
  localparam int CW = $clog2(STARTUP_CYC + 1);
  localparam logic [CW-1:0] CNT_MAX = CW'(STARTUP_CYC);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          rdy_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!en)                 cnt_d = '0;
    else if (cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
    rdy_d = en && (cnt_d == CNT_MAX);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ready <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      ready <= rdy_d;
    end
  end
endmodule

// File: rtl/irb_tick_gen.sv
module irb_tick_gen
  import irb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             tick_d;

  always_comb begin
    cnt_d  = '0;
    tick_d = 1'b0;
    if (run) begin
      if (cnt_q >= (div - 1'b1)) tick_d = 1'b1;
      else                       cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      tick  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      tick  <= tick_d;
    end
  end
endmodule

// File: rtl/irb_cmd_rx.sv
module irb_cmd_rx
  import irb_pkg::*;
#(
  parameter int ECHO_DLY = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              tick,
  input  logic              host_tx,
  output logic              echo_rx,
  output logic              byte_vld,
  output logic [BYTE_W-1:0] byte_q,
  output logic              echo_done
);
  localparam int TW = $clog2(OVS + 1);
  localparam int BW = $clog2(BYTE_W + 3);
  localparam logic [TW-1:0] HALF = TW'(OVS / 2 - 1);
  localparam logic [TW-1:0] FULL = TW'(OVS - 1);
  localparam logic [BW-1:0] STOP_IDX = BW'(BYTE_W + 1);

  logic [2:0]          sync_q;
  logic                line, fall;
  rx_state_e           st_q, st_d;
  logic [TW-1:0]       tcnt_q, tcnt_d;
  logic [BW-1:0]       bidx_q, bidx_d;
  logic [BYTE_W-1:0]   sh_q, sh_d;
  logic                vld_d;
  logic [TW:0]         tail_q, tail_d;
  logic [ECHO_DLY-1:0] dly_q;

  assign line = sync_q[1];
  assign fall = sync_q[2] && !sync_q[1];

  always_comb begin
    st_d   = st_q;
    tcnt_d = tcnt_q;
    bidx_d = bidx_q;
    sh_d   = sh_q;
    vld_d  = 1'b0;
    tail_d = tail_q;
    if (tick && tail_q != '0) tail_d = tail_q - 1'b1;
    case (st_q)
      RX_IDLE: if (fall) begin
        st_d   = RX_FRAME;
        tcnt_d = HALF;
        bidx_d = '0;
      end
      default: if (tick) begin
        if (tcnt_q != '0) tcnt_d = tcnt_q - 1'b1;
        else begin
          tcnt_d = FULL;
          bidx_d = bidx_q + 1'b1;
          if (bidx_q == '0) begin
            if (line) st_d = RX_IDLE;
          end else if (bidx_q == STOP_IDX) begin
            st_d = RX_IDLE;
            if (line) begin
              vld_d  = 1'b1;
              tail_d = (TW+1)'(OVS);
            end
          end else begin
            sh_d = {line, sh_q[BYTE_W-1:1]};
          end
        end
      end
    endcase
    if (!active) begin
      st_d   = RX_IDLE;
      vld_d  = 1'b0;
      tail_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q    <= '1;
      st_q      <= RX_IDLE;
      tcnt_q    <= '0;
      bidx_q    <= '0;
      sh_q      <= '0;
      byte_vld  <= 1'b0;
      tail_q    <= '0;
      echo_done <= 1'b0;
      dly_q     <= '1;
    end else begin
      sync_q    <= {sync_q[1:0], host_tx};
      st_q      <= st_d;
      tcnt_q    <= tcnt_d;
      bidx_q    <= bidx_d;
      sh_q      <= sh_d;
      byte_vld  <= vld_d;
      tail_q    <= tail_d;
      echo_done <= (tail_q == (TW+1)'(1)) && (tail_d == '0);
      if (!active)   dly_q <= '1;
      else if (tick) dly_q <= {dly_q[ECHO_DLY-2:0], line};
    end
  end

  assign byte_q  = sh_q;
  assign echo_rx = active ? dly_q[ECHO_DLY-1] : 1'b1;
endmodule

// File: rtl/irb_baud_sel.sv
module irb_baud_sel
  import irb_pkg::*;
#(
  parameter int STARTUP_CYC = 1000,
  parameter int ECHO_DLY    = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic [2:0] baud_sel,
  input  logic       mode_n,
  input  logic       host_tx,
  output logic       tick,
  output logic       echo_rx,
  output logic       ready
);
  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic              cmd_act_q;
  logic [SEL_W-1:0]  stage_q, stage_d, soft_q, soft_d;
  logic              stage_v_q, stage_v_d, pend_q, pend_d;
  logic              byte_vld, echo_done;
  logic [BYTE_W-1:0] rx_byte;
  logic [SEL_W-1:0]  rx_code;
  logic [DIV_W-1:0]  div;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  irb_startup #(.STARTUP_CYC(STARTUP_CYC)) u_start (
    .clk(clk), .rst_n(rst_int_n), .en(en), .ready(ready)
  );

  assign div = (baud_sel == SEL_SOFT) ? sel_div(soft_q) : sel_div(baud_sel);

  irb_tick_gen u_tick (
    .clk(clk), .rst_n(rst_int_n), .run(ready), .div(div), .tick(tick)
  );

  irb_cmd_rx #(.ECHO_DLY(ECHO_DLY)) u_rx (
    .clk(clk), .rst_n(rst_int_n), .active(cmd_act_q), .tick(tick),
    .host_tx(host_tx), .echo_rx(echo_rx), .byte_vld(byte_vld),
    .byte_q(rx_byte), .echo_done(echo_done)
  );

  assign rx_code = cmd_code(rx_byte);

  always_comb begin
    stage_d   = stage_q;
    stage_v_d = stage_v_q;
    pend_d    = pend_q;
    soft_d    = soft_q;
    if (byte_vld) begin
      if (rx_code != SEL_SOFT) begin
        stage_d   = rx_code;
        stage_v_d = 1'b1;
      end else if (rx_byte == CMD_COMMIT && stage_v_q) begin
        pend_d = 1'b1;
      end
    end
    if (echo_done && pend_q) begin
      soft_d = stage_q;
      pend_d = 1'b0;
    end
    if (!cmd_act_q) pend_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      cmd_act_q <= 1'b0;
      stage_q   <= '0;
      stage_v_q <= 1'b0;
      pend_q    <= 1'b0;
      soft_q    <= '0;
    end else begin
      cmd_act_q <= ready && (baud_sel == SEL_SOFT) && !mode_n;
      stage_q   <= stage_d;
      stage_v_q <= stage_v_d;
      pend_q    <= pend_d;
      soft_q    <= soft_d;
    end
  end
endmodule

// File: rtl/irb_baud_sel_chk.sv
module irb_baud_sel_chk #(
  parameter int MAX_DIV = 48
) (
  input logic       clk,
  input logic       rst_n,
  input logic       en,
  input logic [2:0] baud_sel,
  input logic       mode_n,
  input logic       tick,
  input logic       echo_rx,
  input logic       ready
);
  logic [7:0] gap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              gap_q <= '0;
    else if (!ready || tick) gap_q <= '0;
    else                     gap_q <= gap_q + 1'b1;
  end

  AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);                                                   // R1
  AST_TICK_MAX_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    gap_q <= 8'(MAX_DIV));                                             // R1
  AST_NO_TICK_UNREADY: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |=> !tick);                                                 // R3
  AST_READY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !ready);                                                   // R3
  AST_ECHO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (baud_sel != 3'b111 || mode_n || !ready) |=> echo_rx);             // R4
endmodule

bind irb_baud_sel irb_baud_sel_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .baud_sel(baud_sel), .mode_n(mode_n),
  .tick(tick), .echo_rx(echo_rx), .ready(ready)
);

// File: tb/irb_baud_sel_tb.sv
module irb_baud_sel_tb;
  logic       clk = 1'b0;
  logic       rst_n, en, mode_n, host_tx;
  logic [2:0] baud_sel;
  logic       tick, echo_rx, ready;
  int         n_chk = 0, n_bad = 0, cyc = 0;

  always #10 clk = ~clk;

  irb_baud_sel u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .baud_sel(baud_sel), .mode_n(mode_n),
    .host_tx(host_tx), .tick(tick), .echo_rx(echo_rx), .ready(ready)
  );

  localparam logic [8:0] HW_VEC [5] = '{
    {3'b000, 6'd48}, {3'b001, 6'd24}, {3'b010, 6'd12},
    {3'b011, 6'd8},  {3'b100, 6'd4}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 195000) begin
      chk(1'b0, "watchdog", cyc, 195000);
      finish_run();
    end
  end

  task automatic measure(output int p);
    int n;
    @(negedge clk);
    while (!tick) @(negedge clk);
    n = 0;
    do begin @(negedge clk); n++; end while (!tick);
    p = n;
  endtask

  task automatic wait_ready(output int n);
    n = 0;
    while (!ready) begin @(negedge clk); n++; end
  endtask

  // Send one 8N1 frame; echo sampled 12 ticks into each bit.
  task automatic send(input logic [7:0] b, input bit stop, input int div,
                      input bit echo_on, input string req);
    logic [9:0] bits;
    logic [9:0] seen;
    bits = {stop, b, 1'b0};
    for (int i = 0; i < 10; i++) begin
      host_tx = bits[i];
      repeat (12 * div) @(negedge clk);
      seen[i] = echo_rx;
      repeat (4 * div) @(negedge clk);
    end
    host_tx = 1'b1;
    if (echo_on) chk(seen == bits, req, seen, bits);
    else         chk(seen == 10'h3FF, req, seen, 10'h3FF);
  endtask

  task automatic idle(input int div);
    repeat (32 * div) @(negedge clk);
  endtask

  initial begin
    int p, n;
    rst_n = 1'b0; en = 1'b1; baud_sel = 3'b000; mode_n = 1'b1; host_tx = 1'b1;
    repeat (5) @(negedge clk);
    chk(ready == 1'b0, "R3 reset ready", ready, 0);
    chk(tick == 1'b0, "R3 reset tick", tick, 0);
    chk(echo_rx == 1'b1, "R4 reset echo", echo_rx, 1);
    rst_n = 1'b1;
    wait_ready(n);
    chk(n >= 1000 && n <= 1005, "R3 startup after reset", n, 1000);

    for (int i = 0; i < 5; i++) begin
      baud_sel = HW_VEC[i][8:6];
      repeat (100) @(negedge clk);
      measure(p);
      chk(p == int'(HW_VEC[i][5:0]), "R1 pin rate", p, HW_VEC[i][5:0]);
    end

    baud_sel = 3'b111;
    repeat (100) @(negedge clk);
    measure(p);
    chk(p == 48, "R2 software default", p, 48);

    en = 1'b0;
    repeat (3) @(negedge clk);
    chk(ready == 1'b0, "R3 en low ready", ready, 0);
    n = 0;
    repeat (200) begin @(negedge clk); if (tick) n++; end
    chk(n == 0, "R3 no tick disabled", n, 0);
    en = 1'b1;
    wait_ready(n);
    chk(n >= 1000 && n <= 1003, "R3 startup after en", n, 1000);

    // data mode: bytes ignored, no echo
    send(8'h81, 1'b1, 48, 1'b0, "R10 data-mode echo");
    idle(48);
    send(8'h11, 1'b1, 48, 1'b0, "R10 data-mode echo");
    idle(48);
    measure(p);
    chk(p == 48, "R10 data-mode rate", p, 48);

    mode_n = 1'b0;
    repeat (50) @(negedge clk);
    send(8'h11, 1'b1, 48, 1'b1, "R4 echo commit byte");
    idle(48);
    measure(p);
    chk(p == 48, "R8 commit with nothing staged", p, 48);

    send(8'h83, 1'b0, 48, 1'b1, "R4 echo bad frame");
    idle(48);
    send(8'h11, 1'b1, 48, 1'b1, "R4 echo commit");
    idle(48);
    measure(p);
    chk(p == 48, "R9 bad stop discarded", p, 48);

    send(8'h99, 1'b1, 48, 1'b1, "R4 echo reserved");
    idle(48);
    send(8'h11, 1'b1, 48, 1'b1, "R4 echo commit");
    idle(48);
    measure(p);
    chk(p == 48, "R7 reserved alone ignored", p, 48);

    send(8'h8B, 1'b1, 48, 1'b1, "R5 echo rate byte");
    idle(48);
    send(8'h11, 1'b1, 48, 1'b1, "R5 echo commit");
    measure(p);
    chk(p == 48, "R6 old rate until echoed stop ends", p, 48);
    repeat (40 * 48) @(negedge clk);
    measure(p);
    chk(p == 24, "R5 committed rate", p, 24);

    send(8'h85, 1'b1, 24, 1'b1, "R5 echo at new rate");
    idle(24);
    send(8'h99, 1'b1, 24, 1'b1, "R7 echo reserved");
    idle(24);
    send(8'h11, 1'b1, 24, 1'b1, "R5 echo commit");
    idle(24);
    measure(p);
    chk(p == 12, "R7 reserved keeps staged rate", p, 12);

    baud_sel = 3'b000;
    repeat (100) @(negedge clk);
    measure(p);
    chk(p == 48, "R11 pins override", p, 48);
    chk(echo_rx == 1'b1, "R4 echo idle in pin mode", echo_rx, 1);
    baud_sel = 3'b111;
    repeat (100) @(negedge clk);
    measure(p);
    chk(p == 12, "R11 software rate retained", p, 12);

    mode_n = 1'b1;
    repeat (50) @(negedge clk);
    send(8'h81, 1'b1, 12, 1'b0, "R10 data-mode echo");
    idle(12);
    send(8'h11, 1'b1, 12, 1'b0, "R10 data-mode echo");
    idle(12);
    measure(p);
    chk(p == 12, "R10 data-mode rate kept", p, 12);

    finish_run();
  end
endmodule